// File: doc/BRIEF.md
# Idle-Time Open Page Closer

This block sits beside a DRAM controller and keeps track of which bank in each memory row currently holds an open page. Every bank slot (one per bank per row) has its own inactivity counter. An access to an open page, or an access that opens a new page, loads that counter with a programmable timeout. When the counter runs out, the page is marked stale and queued for closing.

Stale pages are never closed on the controller's demand cycles. A precharge request for the highest-priority stale page is offered only while the controller reports itself idle and no access arrives in that same cycle. Closing stale pages in spare cycles means a later critical access to that memory area does not pay for the close step first.

A stale page that is touched again before its close request is taken becomes live again. A timeout of zero stops automatic closing. The `page_open` vector shows the open state of every slot. The slot index is `row * NUM_BANKS + bank`.

Top module: `idle_page_closer`

## Requirements
- R1: After reset all bits of `page_open` are 0 and `req_valid` is 0.
- R2: An access with `acc_open`=1 sets bit `row*NUM_BANKS+bank` of `page_open`, visible in the cycle after the accepting clock edge.
- R3: An access with `acc_open`=0 to a slot whose page is closed is ignored: the bit stays 0, and the access never causes a request.
- R4: An access to an open slot, or one that opens a slot, loads that slot's counter with `timeout`. The slot becomes stale exactly `timeout` clock edges after the access edge if it has no further access.
- R5: `req_valid` is 1 only in cycles where `ctrl_idle`=1 and `acc_valid`=0. A stale slot stays queued through busy cycles, and no open page closes while `ctrl_idle` is 0.
- R6: When several slots are stale, the request names the lowest slot index, which means the lowest row first and then the lowest bank.
- R7: A request taken with `req_valid`=1 and `req_ready`=1 clears that slot's `page_open` bit and its stale flag at that edge. The next stale slot is offered in the following cycle.
- R8: An access to a stale slot, taken before its request is accepted, clears the stale flag and reloads the counter from `timeout`.
- R9: An access that loads a timeout of 0 leaves the slot open and never makes it stale.
- R10: An access that lands on the same edge at which the slot's counter would expire wins. The slot does not become stale at that edge and is reloaded instead.
- R11: `req_row` equals the stale slot index divided by `NUM_BANKS`, and `req_bank` equals that index modulo `NUM_BANKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A demand access occurs this cycle |
| acc_row | input | ROW_W | Row of the access |
| acc_bank | input | BANK_W | Bank of the access |
| acc_open | input | 1 | 1 = access opens a new page, 0 = hit on the already open page |
| ctrl_idle | input | 1 | Controller has no demand work this cycle |
| timeout | input | TMR_W | Inactivity limit in cycles, 0 disables closing |
| req_valid | output | 1 | Precharge request offered |
| req_ready | input | 1 | Controller takes the offered request |
| req_row | output | ROW_W | Row of the page to close |
| req_bank | output | BANK_W | Bank of the page to close |
| page_open | output | NUM_ROWS*NUM_BANKS | Open state of every slot, indexed row*NUM_BANKS+bank |

## Verification
Two functions can fall in the same cycle: a slot's counter reaching expiry and a fresh access to that same slot. The bench times a hit so that it lands on the edge where the counter moves from one to zero. It then expects no request after that edge and a request exactly `timeout` edges later. A second collision occurs when a hit arrives while a stale slot is being offered. The request must drop in that cycle because of the access. After that the slot is judged live again, and it has to run out a full timeout before it is offered once more.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ipc_slot_timer.sv
module ipc_slot_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,     // access aimed at this slot
  input  logic             open_new,  // that access opens a page
  input  logic             close,     // close request accepted for this slot
  input  logic [TMR_W-1:0] timeout,
  output logic             open_o,
  output logic             stale_o
);
  logic             open_q, stale_q;
  logic [TMR_W-1:0] cnt_q;
  logic             live_touch;

  assign live_touch = touch && (open_q || open_new);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      stale_q <= 1'b0;
      cnt_q   <= '0;
    end else if (live_touch) begin
      open_q  <= 1'b1;
      stale_q <= 1'b0;
      cnt_q   <= timeout;
    end else if (close) begin
      open_q  <= 1'b0;
      stale_q <= 1'b0;
      cnt_q   <= '0;
    end else if (open_q && !stale_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == TMR_W'(1)) stale_q <= 1'b1;
    end
  end

  assign open_o  = open_q;
  assign stale_o = stale_q;

  a_r7_close_clears: assert property (@(posedge clk) disable iff (rst)
    (close && !touch) |=> (!open_q && !stale_q));
  a_r3_hit_on_closed_ignored: assert property (@(posedge clk) disable iff (rst)
    (touch && !open_new && !open_q && !close) |=> !open_q);
  a_r8_touch_revives: assert property (@(posedge clk) disable iff (rst)
    live_touch |=> !stale_q);
  a_r4_expiry_from_one: assert property (@(posedge clk) disable iff (rst)
    $rose(stale_q) |-> ($past(cnt_q) == TMR_W'(1)));
  a_r9_zero_never_stale: assert property (@(posedge clk) disable iff (rst)
    (live_touch && timeout == '0) |=> !stale_q);
  a_r7_stale_needs_open: assert property (@(posedge clk) disable iff (rst)
    stale_q |-> open_q);
endmodule

// File: rtl/ipc_pick.sv
module ipc_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins; the scan runs downward so the last hit is the lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/idle_page_closer.sv
module idle_page_closer
  import ipc_pkg::*;
#(
  parameter int NUM_ROWS  = 2,
  parameter int NUM_BANKS = 4,
  parameter int TMR_W     = 8,
  localparam int ROW_W    = idx_w(NUM_ROWS),
  localparam int BANK_W   = idx_w(NUM_BANKS),
  localparam int SLOTS    = NUM_ROWS * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic              acc_open,
  input  logic              ctrl_idle,
  input  logic [TMR_W-1:0]  timeout,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ROW_W-1:0]  req_row,
  output logic [BANK_W-1:0] req_bank,
  output logic [SLOTS-1:0]  page_open
);
  localparam int SLOT_W = idx_w(SLOTS);

  logic [SLOT_W-1:0] acc_idx, pick_idx;
  logic [SLOTS-1:0]  stale_vec;
  logic              pick_found, accept;

  assign acc_idx = SLOT_W'(int'(acc_row) * NUM_BANKS + int'(acc_bank));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    ipc_slot_timer #(.TMR_W(TMR_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .touch    (acc_valid && (int'(acc_idx) == s)),
      .open_new (acc_open),
      .close    (accept && (int'(pick_idx) == s)),
      .timeout  (timeout),
      .open_o   (page_open[s]),
      .stale_o  (stale_vec[s])
    );
  end

  ipc_pick #(.N(SLOTS), .IW(SLOT_W)) u_pick (
    .vec   (stale_vec),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // Close work only borrows cycles the controller leaves unused.
  assign req_valid = ctrl_idle && !acc_valid && pick_found;
  assign accept    = req_valid && req_ready;
  assign req_row   = ROW_W'(int'(pick_idx) / NUM_BANKS);
  assign req_bank  = BANK_W'(int'(pick_idx) % NUM_BANKS);

  a_r5_busy_closes_nothing: assert property (@(posedge clk) disable iff (rst)
    !ctrl_idle |=> ((~page_open & $past(page_open)) == '0));
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((stale_vec & ((SLOTS'(1) << pick_idx) - SLOTS'(1))) == '0));
  a_r7_accept_closes: assert property (@(posedge clk) disable iff (rst)
    accept |=> !page_open[$past(pick_idx)]);
endmodule

// File: tb/idle_page_closer_test.sv
module idle_page_closer_test;
  localparam int NR = 2, NB = 4, TW = 4, NS = NR * NB;

  logic          clk = 1'b0;
  logic          rst, acc_valid, acc_open, ctrl_idle, req_ready;
  logic [0:0]    acc_row;
  logic [1:0]    acc_bank;
  logic [TW-1:0] timeout;
  logic          req_valid;
  logic [0:0]    req_row;
  logic [1:0]    req_bank;
  logic [NS-1:0] page_open;
  int            checks = 0, fails = 0;

  always #4 clk = ~clk;

  idle_page_closer #(.NUM_ROWS(NR), .NUM_BANKS(NB), .TMR_W(TW)) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_row(acc_row),
    .acc_bank(acc_bank), .acc_open(acc_open), .ctrl_idle(ctrl_idle),
    .timeout(timeout), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_bank(req_bank), .page_open(page_open)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic access(input int r, input int b, input logic op);
    acc_valid = 1'b1;
    acc_row   = r[0:0];
    acc_bank  = b[1:0];
    acc_open  = op;
    tick();
    acc_valid = 1'b0;
    acc_open  = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; acc_valid = 1'b0; acc_open = 1'b0; acc_row = '0; acc_bank = '0;
    req_ready = 1'b0; ctrl_idle = 1'b0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    timeout = 4'd5;
    // Timer reload, busy hold, revive on hit
    do_reset();
    ctrl_idle = 1'b1;
    chk("R1 page_open", int'(page_open), 0);
    chk("R1 req_valid", int'(req_valid), 0);
    access(0, 1, 1'b1);
    chk("R2 page_open", int'(page_open), 2);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R4 early req_valid", int'(req_valid), 0);
    end
    tick();
    chk("R4 req_valid at timeout", int'(req_valid), 1);
    chk("R11 req_row", int'(req_row), 0);
    chk("R11 req_bank", int'(req_bank), 1);
    ctrl_idle = 1'b0; #1;
    chk("R5 busy req_valid", int'(req_valid), 0);
    tick(); tick();
    chk("R5 busy keeps open", int'(page_open), 2);
    ctrl_idle = 1'b1; #1;
    chk("R5 stale persists", int'(req_valid), 1);
    acc_valid = 1'b1; acc_row = 1'b0; acc_bank = 2'd1; acc_open = 1'b0; #1;
    chk("R5 access masks request", int'(req_valid), 0);
    tick();
    acc_valid = 1'b0;
    chk("R8 revived req_valid", int'(req_valid), 0);
    chk("R8 still open", int'(page_open), 2);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R8 reloaded early", int'(req_valid), 0);
    end
    tick();
    chk("R8 stale again", int'(req_valid), 1);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    chk("R7 closed", int'(page_open), 0);
    chk("R7 no request", int'(req_valid), 0);

    // Priority among several stale slots
    do_reset();
    timeout = 4'd3;
    access(1, 3, 1'b1);
    access(0, 2, 1'b1);
    access(1, 0, 1'b1);
    chk("R2 three open", int'(page_open), 148);
    repeat (6) tick();
    chk("R5 busy no close", int'(page_open), 148);
    ctrl_idle = 1'b1; #1;
    chk("R6 first valid", int'(req_valid), 1);
    chk("R6 first index", int'(req_row) * NB + int'(req_bank), 2);
    req_ready = 1'b1;
    tick();
    chk("R7 first closed", int'(page_open), 144);
    chk("R6 second index", int'(req_row) * NB + int'(req_bank), 4);
    tick();
    chk("R7 second closed", int'(page_open), 128);
    chk("R6 third index", int'(req_row) * NB + int'(req_bank), 7);
    tick();
    chk("R7 all closed", int'(page_open), 0);
    chk("R7 queue empty", int'(req_valid), 0);
    req_ready = 1'b0;

    // Zero timeout disables closing
    do_reset();
    timeout = 4'd0;
    ctrl_idle = 1'b1;
    access(0, 0, 1'b1);
    repeat (20) tick();
    chk("R9 no request", int'(req_valid), 0);
    chk("R9 stays open", int'(page_open), 1);
    timeout = 4'd2;
    access(0, 0, 1'b0);
    tick();
    chk("R4 hit reload early", int'(req_valid), 0);
    tick();
    chk("R4 hit reload expiry", int'(req_valid), 1);

    // Access on the expiry edge
    do_reset();
    timeout = 4'd3;
    ctrl_idle = 1'b1;
    access(1, 1, 1'b1);
    tick(); tick();
    chk("R10 before expiry", int'(req_valid), 0);
    access(1, 1, 1'b0);
    chk("R10 access wins", int'(req_valid), 0);
    tick(); tick();
    chk("R10 reloaded early", int'(req_valid), 0);
    tick();
    chk("R10 later expiry", int'(req_valid), 1);
    chk("R11 row", int'(req_row), 1);
    chk("R11 bank", int'(req_bank), 1);

    // Hit on a closed slot
    do_reset();
    timeout = 4'd2;
    ctrl_idle = 1'b1;
    access(1, 0, 1'b0);
    chk("R3 stays closed", int'(page_open), 0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R3 no request", int'(req_valid), 0);
    end
    access(1, 0, 1'b1);
    chk("R2 open after miss", int'(page_open), 16);

    // Sweep every slot with several timeouts
    for (int s = 0; s < NS; s++) begin
      int t;
      t = 1 + s % 3;
      do_reset();
      timeout = TW'(t);
      ctrl_idle = 1'b1;
      access(s / NB, s % NB, 1'b1);
      chk("R2 sweep open", int'(page_open), 1 << s);
      chk("R4 sweep early", int'(req_valid), 0);
      repeat (t) tick();
      chk("R4 sweep expiry", int'(req_valid), 1);
      chk("R11 sweep row", int'(req_row), s / NB);
      chk("R11 sweep bank", int'(req_bank), s % NB);
      req_ready = 1'b1;
      tick();
      req_ready = 1'b0;
      chk("R7 sweep closed", int'(page_open), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule